// File: doc/BRIEF.md
# Branch-Free Absolute Difference Unit

This block takes two signed operands in two's-complement form and returns the unsigned size of their difference, |A − B|. It is meant to sit inside an arithmetic pipeline that must never stall. Every pair costs the same fixed work, and no step depends on the outcome of an earlier one. A new pair may arrive on every clock. Each result leaves the unit a fixed two register stages after its pair entered.

The first stage adds A to the bitwise inverse of B. Both operands are first widened by one sign bit, so the sum equals A − B − 1 and can never overflow. That intermediate value is registered. The second stage is one small arithmetic unit steered only by the sign bit of the intermediate value:

- When the sign bit is clear, the unit adds one.
- When the sign bit is set, the unit inverts every bit.

Either way the result is |A − B|. The unit never has to choose between subtracting and then negating. An input valid flag travels alongside the data. The data registers load only for valid pairs, so an idle cycle leaves the last result in place.

Top module: `absdiff_unit`

## Requirements
- R1: While reset is held, and on the first edge after it is released, outValid is 0 and outMag is 0.
- R2: For every operand pair, outMag equals |opA − opB|. Both operands are read as WIDTH-bit two's-complement values, and the result is read as an unsigned WIDTH-bit value.
- R3: A pair sampled with inValid high at a rising edge appears on outMag just after the next rising edge. At that moment outValid is high, and it stays high for exactly one cycle for that pair. Without an input pair, outValid never rises.
- R4: Pairs may be offered on consecutive clocks with no gap. Each pair produces its own result, in input order, one per clock.
- R5: Edges where inValid is low leave outMag unchanged, whatever values opA and opB carry.
- R6: Equal operands give a result of 0. This is the case where the intermediate A + ~B is −1 and the second stage inverts.
- R7: Both second-stage paths give correct results. When A > B, the intermediate is non-negative and the result is intermediate + 1. When A < B, the intermediate is negative and the result is its bitwise inverse.
- R8: The operand extremes are handled without overflow. (max positive, most negative) and (most negative, max positive) both give 2^WIDTH − 1, which is 4095 at the default WIDTH of 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Marks opA/opB as a pair to process |
| opA | input | WIDTH | Minuend, two's complement |
| opB | input | WIDTH | Subtrahend, two's complement |
| outValid | output | 1 | Marks outMag as a fresh result |
| outMag | output | WIDTH | Unsigned magnitude of opA − opB |

## Verification
The bench targets the sign boundary of the intermediate sum.

- **Equal operands and differences of ±1.** A second stage that used the wrong sign convention, or added one on the wrong path, would give results off by one, or a result of 0 showing up as all ones.
- **The two operand extremes.** A design without the extra sign bit would wrap and report a tiny difference where 4095 is expected.
- **All 256 pairs at a 4-bit width, then a long random stream at 12 bits, both back to back.** These expose a shifted pipeline or a dropped pair as mismatched results.
- **Idle cycles with changing operands.** A data register that loads without regard to inValid would overwrite the last result.

// File: rtl/absdiff_pkg.sv
package absdiff_pkg;

  // Strobes from the control section to the datapath registers.
  typedef struct packed {
    logic loadMid;  // capture the stage-1 sum into the pipe register
    logic loadOut;  // capture the stage-2 result into the output register
  } pipeStrobes_t;

endpackage

// File: rtl/absdiff_stage1.sv
// Stage 1: sign-extend both operands and form A + ~B, which equals A - B - 1.
module absdiff_stage1 #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH:0]   preSum
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] extA;
  logic [EXT_W-1:0] extBInv;

  always_comb begin
    extA    = {opA[WIDTH-1], opA};
    extBInv = ~{opB[WIDTH-1], opB};
    preSum  = extA + extBInv;
  end
endmodule

// File: rtl/absdiff_stage2.sv
// Stage 2: one unit, steered by the sign bit only.
// Sign clear: add one. Sign set: invert the bits.
module absdiff_stage2 #(
  parameter int WIDTH = 12
) (
  input  logic [WIDTH:0]   preSum,
  output logic [WIDTH-1:0] magOut
);
  logic             negSide;
  logic [WIDTH-1:0] flipped;
  logic [WIDTH-1:0] carryIn;

  always_comb begin
    negSide = preSum[WIDTH];
    flipped = preSum[WIDTH-1:0] ^ {WIDTH{negSide}};
    carryIn = {{(WIDTH-1){1'b0}}, ~negSide};
    magOut  = flipped + carryIn;
  end
endmodule

// File: rtl/absdiff_ctrl.sv
// Valid pipeline. It tells the datapath when each register may load.
module absdiff_ctrl
  import absdiff_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output pipeStrobes_t stb,
  output logic         outValid
);
  logic midValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      midValid <= 1'b0;
      outValid <= 1'b0;
    end else begin
      midValid <= inValid;
      outValid <= midValid;
    end
  end

  always_comb begin
    stb.loadMid = inValid;
    stb.loadOut = midValid;
  end

  // R3: an accepted pair always surfaces two sampled edges later
  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R3: a result flag never appears without a pair two edges back
  assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid, 2));
endmodule

// File: rtl/absdiff_dp.sv
// Datapath: stage 1, the pipe register, stage 2 and the output register.
module absdiff_dp
  import absdiff_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  pipeStrobes_t     stb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] outMag
);
  localparam int EXT_W = WIDTH + 1;

  logic [EXT_W-1:0] sumNext;
  logic [EXT_W-1:0] midSum;
  logic [WIDTH-1:0] magNext;

  absdiff_stage1 #(.WIDTH(WIDTH)) u_stage1 (
    .opA    (opA),
    .opB    (opB),
    .preSum (sumNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            midSum <= '0;
    else if (stb.loadMid) midSum <= sumNext;
  end

  absdiff_stage2 #(.WIDTH(WIDTH)) u_stage2 (
    .preSum (midSum),
    .magOut (magNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            outMag <= '0;
    else if (stb.loadOut) outMag <= magNext;
  end

  // Independent reference: subtract the widened operands, then negate if needed.
  function automatic logic [WIDTH-1:0] refMag(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y);
    logic [EXT_W-1:0] d;
    d = {x[WIDTH-1], x} - {y[WIDTH-1], y};
    if (d[WIDTH]) d = -d;
    return d[WIDTH-1:0];
  endfunction

  // R2: a loaded result matches the magnitude of the pair captured one edge before
  assert_magnitude_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |=> outMag == refMag($past(opA, 2), $past(opB, 2)));

  // R5: the output register holds on idle cycles
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadOut |=> $stable(outMag));
endmodule

// File: rtl/absdiff_unit.sv
// Thin top: control plus datapath.
module absdiff_unit
  import absdiff_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic             outValid,
  output logic [WIDTH-1:0] outMag
);
  pipeStrobes_t stb;

  absdiff_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  absdiff_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .opA    (opA),
    .opB    (opB),
    .outMag (outMag)
  );

  // R1: reset clears the outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && outMag == '0));
endmodule

// File: tb/absdiff_unit_tb.sv
module absdiff_unit_tb;
  localparam int WIDE   = 12;
  localparam int NARROW = 4;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic            wV = 1'b0;
  logic [WIDE-1:0] wA = '0;
  logic [WIDE-1:0] wB = '0;
  logic            wOV;
  logic [WIDE-1:0] wM;

  logic              nV = 1'b0;
  logic [NARROW-1:0] nA = '0;
  logic [NARROW-1:0] nB = '0;
  logic              nOV;
  logic [NARROW-1:0] nM;

  absdiff_unit #(.WIDTH(WIDE)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(wV), .opA(wA), .opB(wB),
    .outValid(wOV), .outMag(wM)
  );

  absdiff_unit #(.WIDTH(NARROW)) u_dutNarrow (
    .clk(clk), .rstN(rstN), .inValid(nV), .opA(nA), .opB(nB),
    .outValid(nOV), .outMag(nM)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [WIDE-1:0]   bufA [0:2047];
  logic [WIDE-1:0]   bufB [0:2047];
  logic [NARROW-1:0] nbA  [0:255];
  logic [NARROW-1:0] nbB  [0:255];

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refAbs(input int x, input int y);
    int d;
    d = x - y;
    return (d < 0) ? -d : d;
  endfunction

  function automatic int sW(input logic [WIDE-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int sN(input logic [NARROW-1:0] v);
    return int'($signed(v));
  endfunction

  // R1: outputs are clear in reset and on the first edge after release
  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", "wide valid in reset", int'(wOV), 0);
    check("R1", "wide mag in reset", int'(wM), 0);
    check("R1", "narrow valid in reset", int'(nOV), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "wide valid after release", int'(wOV), 0);
    check("R1", "wide mag after release", int'(wM), 0);
  endtask

  // One isolated pair: checks timing (R3) and the value against a hand-computed answer.
  task automatic onePair(input string req, input int a, input int b, input int exp);
    @(negedge clk);
    wV = 1'b1; wA = WIDE'(a); wB = WIDE'(b);
    @(negedge clk);
    wV = 1'b0;
    check("R3", "valid one edge after capture", int'(wOV), 0);
    @(negedge clk);
    check("R3", "valid two edges after capture", int'(wOV), 1);
    check(req, $sformatf("mag for %0d,%0d", a, b), int'(wM), exp);
    @(negedge clk);
    check("R3", "valid lasts one cycle", int'(wOV), 0);
  endtask

  // R6, R7, R8: directed corner values
  task automatic testDirected();
    onePair("R6", 0, 0, 0);
    onePair("R6", -1234, -1234, 0);
    onePair("R7", 7, 5, 2);
    onePair("R7", 5, 7, 2);
    onePair("R7", -1, 0, 1);
    onePair("R7", 0, -1, 1);
    onePair("R8", 2047, -2048, 4095);
    onePair("R8", -2048, 2047, 4095);
    onePair("R8", -2048, -2048, 0);
  endtask

  // R5: idle cycles with changing operands leave the result in place
  task automatic testHold();
    onePair("R2", 100, 3, 97);
    for (int k = 0; k < 4; k++) begin
      wA = WIDE'(k * 333); wB = WIDE'(-k * 77);
      @(negedge clk);
      check("R5", "mag held while idle", int'(wM), 97);
      check("R5", "valid low while idle", int'(wOV), 0);
    end
  endtask

  // R2, R4: back-to-back random pairs at full width
  task automatic testRandomWide(input int n);
    for (int i = 0; i < n; i++) begin
      bufA[i] = WIDE'($urandom);
      bufB[i] = WIDE'($urandom);
    end
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R4", "stream valid", int'(wOV), 1);
        check("R2", "stream mag", int'(wM), refAbs(sW(bufA[i-2]), sW(bufB[i-2])));
      end
      if (i < n) begin
        wV = 1'b1; wA = bufA[i]; wB = bufB[i];
      end else begin
        wV = 1'b0;
      end
    end
    @(negedge clk);
    check("R3", "valid drops after stream", int'(wOV), 0);
  endtask

  // R2, R4, R6, R7, R8: every pair at 4 bits, back to back
  task automatic testExhaustiveNarrow();
    for (int i = 0; i < 256; i++) begin
      nbA[i] = NARROW'(i >> 4);
      nbB[i] = NARROW'(i);
    end
    for (int i = 0; i < 258; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R4", "narrow stream valid", int'(nOV), 1);
        check("R2", "narrow exhaustive mag", int'(nM), refAbs(sN(nbA[i-2]), sN(nbB[i-2])));
      end
      if (i < 256) begin
        nV = 1'b1; nA = nbA[i]; nB = nbB[i];
      end else begin
        nV = 1'b0;
      end
    end
    @(negedge clk);
    check("R3", "narrow valid drops", int'(nOV), 0);
  endtask

  initial begin
    testReset();
    testDirected();
    testHold();
    testExhaustiveNarrow();
    testRandomWide(2000);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule